// File: doc/BRIEF.md
# Bus Target Command Gate and Retry Controller

This block sits behind the pads of a 32-bit bus target and decides, for every address phase seen on the bus, whether the target claims the transaction and how that single data phase ends. It decodes the four-bit command, checks the byte-enable pattern and looks at two status inputs from the data path. One is the fill level of the 512-entry inbound write buffer. The other is a flag saying that read data has been fetched. From these it gives one of three endings: normal completion, a retry, or a target abort.

The target never accepts more than one data phase. When the initiator asks for a burst, the first phase is completed and a disconnect-without-data follows in the next cycle, so the initiator must come back at the following word address. Each access that ends in a retry or a disconnect is recorded as pending, together with the master that issued it. Until that master repeats the recorded access and it completes, every other master is told to retry. Completed writes produce a push strobe for the buffer. The buffer itself is outside this block.

Top module: `pci_tgt_gate`

## Requirements
- R1: Commands 0010, 0011, 0110, 0111, 1010, 1011, 1100, 1110 and 1111 are claimed. Codes whose bit 0 is 0 are reads and codes whose bit 0 is 1 are writes.
- R2: Commands 0000, 0001, 0100, 0101, 1000, 1001 and 1101 are not claimed, and no completion, retry, abort, disconnect or push follows them.
- R3: For a claimed command, `claim` and exactly one of `done`, `retry` and `abort` are high during the single cycle after the one in which `addr_vld` is sampled high. None of the four is high at any other time.
- R4: A read with `rd_rdy` low is answered with `retry`.
- R5: When `fifo_lvl` is 512 or more, a read or a write is answered with `retry`. A write at level 511 completes.
- R6: `fifo_push` pulses together with `done` for a completed write, and stays low for reads, retries and aborts.
- R7: When `burst` is high and the first phase completes, `disc` is high for one cycle, one cycle after `done`. A retried burst gives no `disc`.
- R8: After a retry or a disconnect, any access from a different `mst_id` is answered with `retry`. The lock lasts until the recorded master completes the same command at the same address, which is the next word address (+4) after a disconnect. The recorded master's other accesses are served normally.
- R9: The byte-enable patterns 1111, 0011, 1100, 0001, 0010, 0100 and 1000 are accepted (active high, bit 0 = lowest byte lane). Any other pattern is claimed and ends in `abort`. Abort takes priority over the buffer-full retry and the read-not-ready retry, but not over the lock refusal of R8.
- R10: Commands 1100 and 1110 behave exactly like 0110, and 1111 behaves exactly like 0111.
- R11: While `rst_n` is low all outputs are low, and reset clears any pending lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_vld | input | 1 | Address phase strobe, one cycle |
| cmd | input | 4 | Bus command code |
| addr | input | 32 | Transaction address |
| be | input | 4 | Byte enables, active high |
| mst_id | input | 3 | Identifier of the requesting master |
| burst | input | 1 | Initiator wants more than one data phase |
| fifo_lvl | input | 10 | Current fill level of the write buffer |
| rd_rdy | input | 1 | Read data for this access is available |
| claim | output | 1 | Transaction claimed |
| done | output | 1 | Data phase completed |
| retry | output | 1 | Retry signalled |
| abort | output | 1 | Target abort signalled |
| disc | output | 1 | Disconnect without data after a completed phase |
| fifo_push | output | 1 | Push the write data into the buffer |

## Verification
Several refusal causes can apply to the same access: a lock held by another master, a byte-enable pattern that is not allowed, a full buffer and read data that is not ready. The vector table sets these causes in pairs, for example a bad pattern with a full buffer or with a read that is not ready. The bench then checks that exactly one ending appears and that it is the one R9 and R8 rank first. A completion with `burst` high is also provoked while a lock is held. This shows that the disconnect on one cycle and the new lock address together decide which master is refused afterwards.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_DONE  = 2'd1,
    RSP_RETRY = 2'd2,
    RSP_ABORT = 2'd3
  } rsp_e;

  localparam int CMD_W = 4;
  localparam int BE_W  = 4;

endpackage

// File: rtl/pci_tgt_cmd_decode.sv
module pci_tgt_cmd_decode
  import pci_tgt_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  input  logic [BE_W-1:0]  be,
  output logic             cmd_ok,
  output logic             is_rd,
  output logic             is_wr,
  output logic             be_ok
);

  always_comb begin
    unique case (cmd)
      4'b0010, 4'b0011, 4'b0110, 4'b0111,
      4'b1010, 4'b1011, 4'b1100, 4'b1110, 4'b1111: cmd_ok = 1'b1;
      default:                                     cmd_ok = 1'b0;
    endcase
  end

  assign is_rd = cmd_ok & ~cmd[0];
  assign is_wr = cmd_ok &  cmd[0];

  always_comb begin
    unique case (be)
      4'b1111, 4'b0011, 4'b1100,
      4'b0001, 4'b0010, 4'b0100, 4'b1000: be_ok = 1'b1;
      default:                            be_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/pci_tgt_pend_track.sv
module pci_tgt_pend_track
  import pci_tgt_pkg::*;
#(
  parameter int AW   = 32,
  parameter int MIDW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set,
  input  logic             clr,
  input  logic [CMD_W-1:0] set_cmd,
  input  logic [AW-1:0]    set_addr,
  input  logic [MIDW-1:0]  set_mid,
  output logic             pend_v,
  output logic [CMD_W-1:0] pend_cmd,
  output logic [AW-1:0]    pend_addr,
  output logic [MIDW-1:0]  pend_mid
);

  logic             v_d;
  logic [CMD_W-1:0] cmd_d;
  logic [AW-1:0]    addr_d;
  logic [MIDW-1:0]  mid_d;
  logic             load_en;

  assign load_en = set;

  always_comb begin
    v_d = pend_v;
    if (set)      v_d = 1'b1;
    else if (clr) v_d = 1'b0;
    cmd_d  = set_cmd;
    addr_d = set_addr;
    mid_d  = set_mid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_v <= 1'b0;
    else        pend_v <= v_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_cmd  <= '0;
      pend_addr <= '0;
      pend_mid  <= '0;
    end else if (load_en) begin
      pend_cmd  <= cmd_d;
      pend_addr <= addr_d;
      pend_mid  <= mid_d;
    end
  end

  // R8: a lock is only released by a completing matching access
  a_r8_release_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_v) |-> $past(clr));

  // R8: a lock is only raised by a retry or disconnect decision
  a_r8_raise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_v) |-> $past(set));

endmodule

// File: rtl/pci_tgt_gate.sv
module pci_tgt_gate
  import pci_tgt_pkg::*;
#(
  parameter int AW         = 32,
  parameter int MIDW       = 3,
  parameter int FIFO_DEPTH = 512,
  parameter int LVL_W      = $clog2(FIFO_DEPTH + 1),
  parameter int WORD_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_vld,
  input  logic [3:0]       cmd,
  input  logic [AW-1:0]    addr,
  input  logic [3:0]       be,
  input  logic [MIDW-1:0]  mst_id,
  input  logic             burst,
  input  logic [LVL_W-1:0] fifo_lvl,
  input  logic             rd_rdy,
  output logic             claim,
  output logic             done,
  output logic             retry,
  output logic             abort,
  output logic             disc,
  output logic             fifo_push
);

  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(FIFO_DEPTH);
  localparam logic [AW-1:0]    STEP     = AW'(WORD_BYTES);

  logic             cmd_ok, is_rd, is_wr, be_ok;
  logic             pend_v;
  logic [CMD_W-1:0] pend_cmd;
  logic [AW-1:0]    pend_addr;
  logic [MIDW-1:0]  pend_mid;
  logic             lock_block, pend_match, buf_full;
  logic             take;
  rsp_e             rsp_d, rsp_q;
  logic             claim_d, push_d, burst_d;
  logic             claim_q, push_q, burst_q, disc_q;
  logic             pset, pclr;
  logic [AW-1:0]    pset_addr;

  pci_tgt_cmd_decode u_dec (
    .cmd    (cmd),
    .be     (be),
    .cmd_ok (cmd_ok),
    .is_rd  (is_rd),
    .is_wr  (is_wr),
    .be_ok  (be_ok)
  );

  pci_tgt_pend_track #(.AW(AW), .MIDW(MIDW)) u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .set       (pset),
    .clr       (pclr),
    .set_cmd   (cmd),
    .set_addr  (pset_addr),
    .set_mid   (mst_id),
    .pend_v    (pend_v),
    .pend_cmd  (pend_cmd),
    .pend_addr (pend_addr),
    .pend_mid  (pend_mid)
  );

  assign take       = addr_vld & cmd_ok;
  assign lock_block = pend_v & (mst_id != pend_mid);
  assign pend_match = pend_v & (mst_id == pend_mid) &
                      (cmd == pend_cmd) & (addr == pend_addr);
  assign buf_full   = fifo_lvl >= FULL_LVL;

  // Response priority: lock refusal, byte-enable abort, buffer full, read not ready
  always_comb begin
    rsp_d = RSP_NONE;
    if (take) begin
      if (lock_block)          rsp_d = RSP_RETRY;
      else if (!be_ok)         rsp_d = RSP_ABORT;
      else if (buf_full)       rsp_d = RSP_RETRY;
      else if (is_rd && !rd_rdy) rsp_d = RSP_RETRY;
      else                     rsp_d = RSP_DONE;
    end
  end

  always_comb begin
    claim_d   = take;
    push_d    = (rsp_d == RSP_DONE) & is_wr;
    burst_d   = take & burst;
    pset      = ((rsp_d == RSP_RETRY) & ~lock_block) |
                ((rsp_d == RSP_DONE) & burst);
    pset_addr = (rsp_d == RSP_DONE) ? addr + STEP : addr;
    pclr      = (rsp_d == RSP_DONE) & pend_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      claim_q <= 1'b0;
      rsp_q   <= RSP_NONE;
      push_q  <= 1'b0;
      burst_q <= 1'b0;
      disc_q  <= 1'b0;
    end else begin
      claim_q <= claim_d;
      rsp_q   <= rsp_d;
      push_q  <= push_d;
      burst_q <= burst_d;
      disc_q  <= (rsp_q == RSP_DONE) & burst_q;
    end
  end

  assign claim     = claim_q;
  assign done      = rsp_q == RSP_DONE;
  assign retry     = rsp_q == RSP_RETRY;
  assign abort     = rsp_q == RSP_ABORT;
  assign fifo_push = push_q;
  assign disc      = disc_q;

  // R3: claim follows an address strobe by one cycle
  a_r3_claim_timing: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> $past(addr_vld));

  // R3: a claimed access carries exactly one ending
  a_r3_one_ending: assert property (@(posedge clk) disable iff (!rst_n)
    claim |-> $onehot({done, retry, abort}));

  // R3: no ending without a claim
  a_r3_no_stray: assert property (@(posedge clk) disable iff (!rst_n)
    (done | retry | abort) |-> claim);

  // R5: nothing completes against a full buffer
  a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(fifo_lvl) < FULL_LVL) || $past(lock_block));

  // R6: a push only accompanies a completion
  a_r6_push_done: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> done);

  // R7: a disconnect only follows a completed phase
  a_r7_disc_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    disc |-> $past(done));

endmodule

// File: tb/pci_tgt_gate_test.sv
module pci_tgt_gate_test;

  logic        clk;
  logic        rst_n;
  logic        addr_vld;
  logic [3:0]  cmd;
  logic [31:0] addr;
  logic [3:0]  be;
  logic [2:0]  mst_id;
  logic        burst;
  logic [9:0]  fifo_lvl;
  logic        rd_rdy;
  logic        claim, done, retry, abort, disc, fifo_push;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  pci_tgt_gate uut (
    .clk(clk), .rst_n(rst_n), .addr_vld(addr_vld), .cmd(cmd), .addr(addr),
    .be(be), .mst_id(mst_id), .burst(burst), .fifo_lvl(fifo_lvl),
    .rd_rdy(rd_rdy), .claim(claim), .done(done), .retry(retry),
    .abort(abort), .disc(disc), .fifo_push(fifo_push)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // expected bits: {claim, done, retry, abort, push, disc}
  typedef struct packed {
    logic [3:0] c;
    logic [3:0] b;
    logic [9:0] l;
    logic       r;
    logic       u;
    logic [5:0] e;
  } vec_t;

  localparam int NV = 33;
  localparam vec_t VEC [NV] = '{
    '{4'b0010, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b110000}, // R1 io rd
    '{4'b0011, 4'b1111, 10'd0,   1'b0, 1'b0, 6'b110010}, // R1 io wr
    '{4'b0110, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b110000}, // R1 mem rd
    '{4'b0111, 4'b1111, 10'd0,   1'b0, 1'b0, 6'b110010}, // R1 mem wr
    '{4'b1010, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b110000}, // R1 cfg rd
    '{4'b1011, 4'b1111, 10'd0,   1'b0, 1'b0, 6'b110010}, // R1 cfg wr
    '{4'b1100, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b110000}, // R10 rd mult
    '{4'b1110, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b110000}, // R10 rd line
    '{4'b1111, 4'b1111, 10'd0,   1'b0, 1'b0, 6'b110010}, // R10 wr inv
    '{4'b0000, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b000000}, // R2
    '{4'b0001, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b000000}, // R2
    '{4'b0100, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b000000}, // R2
    '{4'b0101, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b000000}, // R2
    '{4'b1000, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b000000}, // R2
    '{4'b1001, 4'b1111, 10'd0,   1'b1, 1'b0, 6'b000000}, // R2
    '{4'b1101, 4'b1111, 10'd0,   1'b1, 1'b1, 6'b000000}, // R2 burst too
    '{4'b0110, 4'b1111, 10'd0,   1'b0, 1'b0, 6'b101000}, // R4
    '{4'b1100, 4'b1111, 10'd0,   1'b0, 1'b0, 6'b101000}, // R10 R4
    '{4'b1110, 4'b1111, 10'd0,   1'b0, 1'b0, 6'b101000}, // R10 R4
    '{4'b0111, 4'b1111, 10'd512, 1'b0, 1'b0, 6'b101000}, // R5 wr full
    '{4'b0110, 4'b1111, 10'd512, 1'b1, 1'b0, 6'b101000}, // R5 rd full
    '{4'b0111, 4'b1111, 10'd511, 1'b0, 1'b0, 6'b110010}, // R5 511
    '{4'b0111, 4'b0011, 10'd0,   1'b0, 1'b0, 6'b110010}, // R9 low half
    '{4'b0111, 4'b1100, 10'd0,   1'b0, 1'b0, 6'b110010}, // R9 high half
    '{4'b0111, 4'b0100, 10'd0,   1'b0, 1'b0, 6'b110010}, // R9 byte
    '{4'b0111, 4'b0111, 10'd0,   1'b0, 1'b0, 6'b100100}, // R9 24-bit
    '{4'b0111, 4'b0110, 10'd0,   1'b0, 1'b0, 6'b100100}, // R9 unaligned
    '{4'b0111, 4'b0000, 10'd0,   1'b0, 1'b0, 6'b100100}, // R9 none
    '{4'b0111, 4'b1110, 10'd512, 1'b0, 1'b0, 6'b100100}, // R9 over full
    '{4'b0110, 4'b0101, 10'd0,   1'b0, 1'b0, 6'b100100}, // R9 over not-ready
    '{4'b0111, 4'b1111, 10'd0,   1'b0, 1'b1, 6'b110011}, // R7 wr burst
    '{4'b0110, 4'b1111, 10'd0,   1'b0, 1'b1, 6'b101000}, // R7 retried burst
    '{4'b0110, 4'b1111, 10'd0,   1'b1, 1'b1, 6'b110001}  // R7 rd burst
  };

  task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic access(input string tag, input logic [3:0] c, input logic [31:0] a,
                        input logic [3:0] b, input logic [2:0] m, input logic [9:0] l,
                        input logic r, input logic u, input logic [5:0] e);
    @(negedge clk);
    addr_vld = 1'b1; cmd = c; addr = a; be = b; mst_id = m;
    fifo_lvl = l; rd_rdy = r; burst = u;
    @(negedge clk);
    addr_vld = 1'b0;
    check(tag, {1'b0, claim, done, retry, abort, fifo_push}, {1'b0, e[5:1]});
    @(negedge clk);
    check(tag, {5'b0, disc}, {5'b0, e[0]});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R11 reset outputs", {claim, done, retry, abort, disc, fifo_push}, 6'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    addr_vld = 0; cmd = 0; addr = 0; be = 0; mst_id = 0;
    burst = 0; fifo_lvl = 0; rd_rdy = 0;
    do_reset();

    for (int i = 0; i < NV; i++) begin
      access($sformatf("vector %0d", i), VEC[i].c, 32'h100, VEC[i].b, 3'd0,
             VEC[i].l, VEC[i].r, VEC[i].u, VEC[i].e);
    end

    // R8 lock after a retry
    do_reset();
    access("R8 m1 retry",          4'b0110, 32'h200, 4'hF, 3'd1, 10'd0, 1'b0, 1'b0, 6'b101000);
    access("R8 m2 refused",        4'b0111, 32'h300, 4'hF, 3'd2, 10'd0, 1'b1, 1'b0, 6'b101000);
    access("R8 m1 other access",   4'b0111, 32'h400, 4'hF, 3'd1, 10'd0, 1'b1, 1'b0, 6'b110010);
    access("R8 m2 still refused",  4'b0111, 32'h300, 4'hF, 3'd2, 10'd0, 1'b1, 1'b0, 6'b101000);
    access("R8 m2 bad be refused", 4'b0111, 32'h300, 4'h7, 3'd2, 10'd0, 1'b1, 1'b0, 6'b101000);
    access("R8 m1 repeat done",    4'b0110, 32'h200, 4'hF, 3'd1, 10'd0, 1'b1, 1'b0, 6'b110000);
    access("R8 m2 served",         4'b0111, 32'h300, 4'hF, 3'd2, 10'd0, 1'b1, 1'b0, 6'b110010);

    // R8 lock after a disconnect, resume at next word
    access("R8 R7 m2 burst",       4'b0111, 32'h500, 4'hF, 3'd2, 10'd0, 1'b1, 1'b1, 6'b110011);
    access("R8 m3 refused",        4'b0110, 32'h600, 4'hF, 3'd3, 10'd0, 1'b1, 1'b0, 6'b101000);
    access("R8 m2 old addr",       4'b0111, 32'h500, 4'hF, 3'd2, 10'd0, 1'b1, 1'b0, 6'b110010);
    access("R8 m3 still refused",  4'b0110, 32'h600, 4'hF, 3'd3, 10'd0, 1'b1, 1'b0, 6'b101000);
    access("R8 m2 next word",      4'b0111, 32'h504, 4'hF, 3'd2, 10'd0, 1'b1, 1'b0, 6'b110010);
    access("R8 m3 served",         4'b0110, 32'h600, 4'hF, 3'd3, 10'd0, 1'b1, 1'b0, 6'b110000);

    // R11 reset drops a held lock
    access("R11 m1 retry",         4'b0010, 32'h700, 4'hF, 3'd1, 10'd0, 1'b0, 1'b0, 6'b101000);
    do_reset();
    access("R11 m4 after reset",   4'b0011, 32'h800, 4'hF, 3'd4, 10'd0, 1'b0, 1'b0, 6'b110010);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule